// File: doc/BRIEF.md
# UART Serial Transmit Path with Holding FIFO

This block turns host-written bytes into an asynchronous serial stream for one UART channel. Bytes enter a holding store. That store is either a one-byte register or a 16-entry first-in first-out queue, and a FIFO enable input picks which. A serializer takes each byte from the store into its own shift register. It then drives the line with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period.

Everything advances on a one-cycle oversampling enable, `tick_i`. One bit lasts 16, 8 or 4 ticks. Two status flags report whether the holding store and the shifter are empty. A transmit-empty interrupt is raised when the store drains. In single-register mode "drains" means the register is empty. In FIFO mode it means the fill level has dropped below a selectable trigger level. The host clears the interrupt either by writing data or by reading the interrupt status, which the `isr_rd_i` strobe signals.

Top module: `uart_tx_path`

## Requirements
- R1: A bit lasts `os_sel_i` ticks: 2'b00 and 2'b11 give 16, 2'b01 gives 8, 2'b10 gives 4.
- R2: `txd_o` idles at 1 and is 1 after reset. A frame is one start bit at 0, then the data bits, then a parity bit only when `par_en_i` is 1, then a stop period at 1.
- R3: Data bit 0 goes out first. `char_len_i` values 2'b00, 2'b01, 2'b10 and 2'b11 select 5, 6, 7 and 8 data bits.
- R4: `par_mode_i` selects the parity bit. 2'b00 is odd: the total count of ones over the data and parity bits is odd. 2'b01 is even. 2'b10 forces 1 and 2'b11 forces 0.
- R5: With `stop2_i` at 0 the stop period is one bit time. With `stop2_i` at 1 it is two bit times, except that with 5 data bits it is 1.5 bit times.
- R6: A byte is loaded on a tick while the serializer is idle, or on the final tick of a stop period. On that final tick the next start bit follows with no idle gap.
- R7: The holding store keeps 16 bytes in write order in FIFO mode and 1 byte in single-register mode. A write while the store is full is ignored.
- R8: Any change of `fifo_en_i` empties the holding store. No byte is loaded in the cycle where the change is seen.
- R9: `hold_empty_o` is 1 whenever the holding store is empty. In single-register mode it rises in the cycle after the byte moves into the shifter.
- R10: `shift_empty_o` is 1 while the serializer is idle. In FIFO mode it also requires the FIFO to be empty.
- R11: The interrupt condition is "store empty" in single-register mode. In FIFO mode it is "fill level below the trigger": `trig_sel_i` values 2'b00, 2'b01, 2'b10 and 2'b11 give 1, 4, 8 and 14 entries. A pending flag is set in the cycle after the condition goes from false to true. `irq_o` is the pending flag ANDed with `irq_en_i`.
- R12: An accepted write or an `isr_rd_i` pulse clears the pending flag. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, one cycle per tick |
| fifo_en_i | input | 1 | 1 selects the 16-entry FIFO, 0 the single holding register |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| os_sel_i | input | 2 | Ticks per bit select |
| char_len_i | input | 2 | Data bit count select |
| par_en_i | input | 1 | Parity bit enable |
| par_mode_i | input | 2 | Parity kind |
| stop2_i | input | 1 | Long stop period select |
| trig_sel_i | input | 2 | FIFO interrupt trigger level select |
| irq_en_i | input | 1 | Transmit-empty interrupt enable |
| isr_rd_i | input | 1 | Interrupt status read strobe, clears the pending flag |
| txd_o | output | 1 | Serial line output |
| hold_empty_o | output | 1 | Holding store empty |
| shift_empty_o | output | 1 | Shifter empty (and FIFO empty in FIFO mode) |
| irq_o | output | 1 | Transmit-empty interrupt |

## Verification
A behavioural model built on a byte queue is compared with every output on every clock. It is driven with the following patterns:
- A byte written while another is shifting. This separates a correct gapless hand-off from a late or early load.
- A write to a full holding register or a full FIFO. This shows that no extra byte reaches the line.
- Frames at 16, 8 and 4 ticks per bit with ticks on every cycle or on every second cycle. These separate a wrong bit length from a wrong tick gating.
- Parity, character length and stop settings swept across all four parity kinds and the 1.5-stop case.
- A FIFO filled with ticks stopped and then drained. The interrupt must rise exactly as the level crosses the trigger.
- A FIFO enable change while bytes are queued. This tells a real flush from a stale byte that leaks onto the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  localparam int TICK_W = 6;

  function automatic logic [TICK_W-1:0] bit_ticks(input logic [1:0] sel);
    case (sel)
      2'b01:   return TICK_W'(8);
      2'b10:   return TICK_W'(4);
      default: return TICK_W'(16);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] stop_ticks(input logic [1:0] sel,
                                                   input logic       two,
                                                   input logic [1:0] clen);
    logic [TICK_W-1:0] b;
    b = bit_ticks(sel);
    if (!two)              return b;
    else if (clen == 2'b00) return b + (b >> 1);
    else                   return b << 1;
  endfunction

endpackage

// File: rtl/uart_tx_hold_buf.sv
module uart_tx_hold_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          wr_ok_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, cap;
  logic          fen_q, flush;

  assign flush   = fifo_en_i != fen_q;
  assign cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign wr_ok_o = wr_en_i && !flush && (count < cap);
  assign valid_o = (count != '0) && !flush;
  assign data_o  = mem[rd_ptr];
  assign count_o = count;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok_o) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q  <= 1'b0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      fen_q <= fifo_en_i;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
      end else begin
        if (pop_i)   rd_ptr <= inc(rd_ptr);
        if (wr_ok_o) wr_ptr <= inc(wr_ptr);
        count <= count + CW'(wr_ok_o) - CW'(pop_i);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush && count == cap && !pop_i) |=> (count == $past(count))); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count == '0)); // R8
  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R6

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    os_sel_i,
  input  logic [1:0]    char_len_i,
  input  logic          par_en_i,
  input  logic [1:0]    par_mode_i,
  input  logic          stop2_i,
  output logic          pop_o,
  output logic          idle_o,
  output logic          txd_o
);

  tx_state_e         state;
  logic [TICK_W-1:0] tcnt, bit_len, stop_len;
  logic [IW-1:0]     bidx, nb_m1;
  logic [DW-1:0]     shreg;
  logic              par_q, par_bit, data_x, bit_end, stop_end, load;

  assign bit_len  = bit_ticks(os_sel_i);
  assign stop_len = stop_ticks(os_sel_i, stop2_i, char_len_i);
  assign nb_m1    = IW'(char_len_i) + IW'(4);
  assign bit_end  = tick_i && (tcnt == bit_len - TICK_W'(1));
  assign stop_end = tick_i && (tcnt == stop_len - TICK_W'(1));
  assign load     = tick_i && valid_i &&
                    (state == TX_IDLE || (state == TX_STOP && stop_end));
  assign pop_o    = load;
  assign idle_o   = state == TX_IDLE;

  always_comb begin
    data_x = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i <= int'(nb_m1)) data_x = data_x ^ data_i[i];
    case (par_mode_i)
      2'b00:   par_bit = ~data_x;
      2'b01:   par_bit = data_x;
      2'b10:   par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = shreg[0];
      TX_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= TX_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      par_q <= 1'b0;
    end else if (load) begin
      state <= TX_START;
      tcnt  <= '0;
      shreg <= data_i;
      par_q <= par_bit;
    end else if (tick_i) begin
      case (state)
        TX_START: begin
          if (bit_end) begin
            state <= TX_DATA;
            tcnt  <= '0;
            bidx  <= '0;
          end else tcnt <= tcnt + TICK_W'(1);
        end
        TX_DATA: begin
          if (bit_end) begin
            tcnt <= '0;
            if (bidx == nb_m1) state <= par_en_i ? TX_PAR : TX_STOP;
            else begin
              bidx  <= bidx + IW'(1);
              shreg <= shreg >> 1;
            end
          end else tcnt <= tcnt + TICK_W'(1);
        end
        TX_PAR: begin
          if (bit_end) begin
            state <= TX_STOP;
            tcnt  <= '0;
          end else tcnt <= tcnt + TICK_W'(1);
        end
        TX_STOP: begin
          if (stop_end) begin
            state <= TX_IDLE;
            tcnt  <= '0;
          end else tcnt <= tcnt + TICK_W'(1);
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !txd_o); // R2
  AST_STOP_TO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TX_STOP && !stop_end) |=> txd_o); // R5

endmodule

// File: rtl/uart_tx_irq_ctl.sv
module uart_tx_irq_ctl #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          irq_en_i,
  input  logic          wr_ok_i,
  input  logic          isr_rd_i,
  output logic          irq_o
);

  logic [CW-1:0] trig;
  logic          cond, cond_q, set_ev, pend;

  always_comb begin
    case (trig_sel_i)
      2'b00:   trig = CW'(1);
      2'b01:   trig = CW'(4);
      2'b10:   trig = CW'(8);
      default: trig = CW'(14);
    endcase
  end

  assign cond   = fifo_en_i ? (count_i < trig) : (count_i == '0);
  assign set_ev = cond && !cond_q;
  assign irq_o  = irq_en_i && pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      cond_q <= cond;
      if (set_ev)                   pend <= 1'b1;
      else if (wr_ok_i || isr_rd_i) pend <= 1'b0;
    end
  end

  AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_ev && (wr_ok_i || isr_rd_i)) |=> !irq_o); // R12
  AST_IRQ_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> (irq_o == irq_en_i)); // R11

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          fifo_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    os_sel_i,
  input  logic [1:0]    char_len_i,
  input  logic          par_en_i,
  input  logic [1:0]    par_mode_i,
  input  logic          stop2_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          irq_en_i,
  input  logic          isr_rd_i,
  output logic          txd_o,
  output logic          hold_empty_o,
  output logic          shift_empty_o,
  output logic          irq_o
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          valid, pop, wr_ok, idle;
  logic [DW-1:0] head;
  logic [CW-1:0] count;

  uart_tx_hold_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_hold (
    .clk_i, .rst_ni, .fifo_en_i, .wr_en_i, .wr_data_i,
    .pop_i(pop), .valid_o(valid), .data_o(head), .count_o(count), .wr_ok_o(wr_ok)
  );

  uart_tx_serializer #(.DW(DW)) u_ser (
    .clk_i, .rst_ni, .tick_i, .valid_i(valid), .data_i(head),
    .os_sel_i, .char_len_i, .par_en_i, .par_mode_i, .stop2_i,
    .pop_o(pop), .idle_o(idle), .txd_o
  );

  uart_tx_irq_ctl #(.CW(CW)) u_irq (
    .clk_i, .rst_ni, .fifo_en_i, .count_i(count), .trig_sel_i, .irq_en_i,
    .wr_ok_i(wr_ok), .isr_rd_i, .irq_o
  );

  assign hold_empty_o  = count == '0;
  assign shift_empty_o = idle && (!fifo_en_i || count == '0);

  AST_HOLD_EMPTY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && pop && !wr_ok) |=> hold_empty_o); // R9
  AST_SHIFT_BUSY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> !shift_empty_o); // R10

endmodule

// File: tb/uart_tx_path_bench.sv
module uart_tx_path_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, fifo_en = 1'b0, wr_en = 1'b0, par_en = 1'b0, stop2 = 1'b0;
  logic irq_en = 1'b0, isr_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] os_sel = 2'b00, char_len = 2'b11, par_mode = 2'b00, trig_sel = 2'b00;
  logic txd, hold_empty, shift_empty, irq;

  int checks = 0, errors = 0, tick_per = 1, tdiv = 0;
  bit done = 1'b0;
  string scen = "reset";

  always #2 clk = ~clk;

  uart_tx_path u_uart_tx_path (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fifo_en_i(fifo_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .os_sel_i(os_sel), .char_len_i(char_len),
    .par_en_i(par_en), .par_mode_i(par_mode), .stop2_i(stop2), .trig_sel_i(trig_sel),
    .irq_en_i(irq_en), .isr_rd_i(isr_rd), .txd_o(txd), .hold_empty_o(hold_empty),
    .shift_empty_o(shift_empty), .irq_o(irq)
  );

  // Tick source: tick_per==0 stops ticks
  always @(posedge clk) begin
    #1;
    if (tick_per == 0) tick = 1'b0;
    else if (tdiv >= tick_per - 1) begin tick = 1'b1; tdiv = 0; end
    else begin tick = 1'b0; tdiv++; end
  end

  // ---------------- reference model ----------------
  byte unsigned mq[$];
  int  m_phase, m_cnt, m_idx;
  bit  m_fen_q, m_condq, m_pend, m_par;
  byte unsigned m_sh;

  function automatic int bitlen(logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 4 : 16;
  endfunction
  function automatic int stoplen(logic [1:0] s, logic two, logic [1:0] cl);
    if (!two) return bitlen(s);
    return (cl == 2'b00) ? bitlen(s) * 3 / 2 : bitlen(s) * 2;
  endfunction
  function automatic int triglvl(logic [1:0] t);
    return (t == 2'b00) ? 1 : (t == 2'b01) ? 4 : (t == 2'b10) ? 8 : 14;
  endfunction
  function automatic bit parity(byte unsigned b, int nb, logic [1:0] pm);
    bit x = 0;
    for (int i = 0; i < nb; i++) x ^= b[i];
    case (pm)
      2'b00: return ~x;
      2'b01: return x;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_phase = 0; m_cnt = 0; m_idx = 0; m_sh = 0; m_par = 0;
      m_fen_q = 0; m_condq = 1; m_pend = 0;
    end else begin
      bit flush, valid, cond, wok, pop, ld;
      int sz, cap, bl, sl, nb;
      flush = (fifo_en != m_fen_q);
      sz    = mq.size();
      cap   = fifo_en ? 16 : 1;
      valid = (sz > 0) && !flush;
      cond  = fifo_en ? (sz < triglvl(trig_sel)) : (sz == 0);
      wok   = wr_en && !flush && (sz < cap);
      if (cond && !m_condq) m_pend = 1;
      else if (wok || isr_rd) m_pend = 0;
      m_condq = cond;
      bl = bitlen(os_sel); sl = stoplen(os_sel, stop2, char_len); nb = 5 + char_len;
      pop = 0; ld = 0;
      if (tick) begin
        case (m_phase)
          0: ld = valid;
          1: if (m_cnt == bl - 1) begin m_phase = 2; m_cnt = 0; m_idx = 0; end else m_cnt++;
          2: if (m_cnt == bl - 1) begin
               m_cnt = 0;
               if (m_idx == nb - 1) m_phase = par_en ? 3 : 4;
               else begin m_idx++; m_sh = m_sh >> 1; end
             end else m_cnt++;
          3: if (m_cnt == bl - 1) begin m_phase = 4; m_cnt = 0; end else m_cnt++;
          default: if (m_cnt == sl - 1) begin
                     if (valid) ld = 1; else begin m_phase = 0; m_cnt = 0; end
                   end else m_cnt++;
        endcase
        if (ld) begin
          m_sh = mq[0]; m_par = parity(mq[0], nb, par_mode);
          m_phase = 1; m_cnt = 0; pop = 1;
        end
      end
      if (flush) mq.delete();
      else begin
        if (pop) void'(mq.pop_front());
        if (wok) mq.push_back(wr_data);
      end
      m_fen_q = fifo_en;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t: got %b exp %b", tag, scen, $time, got, exp);
    end
  endtask

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic et;
      case (m_phase)
        0: et = 1'b1;
        1: et = 1'b0;
        2: et = m_sh[0];
        3: et = m_par;
        default: et = 1'b1;
      endcase
      chk("R2 txd", txd, et);
      chk("R9 hold_empty", hold_empty, mq.size() == 0);
      chk("R10 shift_empty", shift_empty, (m_phase == 0) && (!fifo_en || mq.size() == 0));
      chk("R11 irq", irq, irq_en && m_pend);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(byte unsigned b);
    wr_en = 1'b1; wr_data = b; cyc(1); wr_en = 1'b0;
  endtask
  task automatic rd_isr();
    isr_rd = 1'b1; cyc(1); isr_rd = 1'b0;
  endtask
  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      cyc(1);
      if (hold_empty && shift_empty) break;
    end
    cyc(3);
    chk("R2 idle line", txd, 1'b1);
    chk("R9 drained", hold_empty, 1'b1);
  endtask
  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got hung exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R2 R9 R10: reset state
    chk("R2 reset txd", txd, 1'b1);
    chk("R9 reset hold_empty", hold_empty, 1'b1);
    chk("R10 reset shift_empty", shift_empty, 1'b1);
    chk("R11 reset irq", irq, 1'b0);

    // R1 R3 R6 R7 R12: single register, 16x, 8 bits
    scen = "single_16x";
    irq_en = 1'b1;
    wr(8'hA5); cyc(3);
    wr(8'h3C);           // R6: held while shifting, loaded without gap
    wr(8'hFF);           // R7: register full, ignored
    cyc(40);
    rd_isr(); cyc(5);    // R12
    drain();
    rd_isr(); cyc(2);
    chk("R12 irq after status read", irq, 1'b0);

    // R1 R4 R5: 8x, 7 bits, even parity, two stops, tick every second cycle
    scen = "single_8x_even";
    tick_per = 2; os_sel = 2'b01; char_len = 2'b10; par_en = 1'b1; par_mode = 2'b01; stop2 = 1'b1;
    wr(8'h55); cyc(2); wr(8'h0F);
    drain();

    // R4 R5: 4x, 5 bits, 1.5 stops, all parity kinds
    scen = "single_4x_5bit";
    tick_per = 1; os_sel = 2'b10; char_len = 2'b00;
    for (int k = 0; k < 4; k++) begin
      par_mode = 2'(k);
      wr(8'h13 + 8'(k * 7)); cyc(1); wr(8'h0B);
      drain();
    end

    // R1 R3: select 2'b11 gives 16 ticks, 6 bits, no parity
    scen = "single_16x_sel3";
    os_sel = 2'b11; char_len = 2'b01; par_en = 1'b0; stop2 = 1'b0;
    wr(8'h2D);
    drain();

    // R7 R11 R12: FIFO fill with ticks stopped, then drain across trigger
    scen = "fifo_fill";
    tick_per = 0; fifo_en = 1'b1; trig_sel = 2'b10; os_sel = 2'b10; char_len = 2'b11;
    cyc(2);
    for (int i = 0; i < 18; i++) wr(8'(i * 17 + 3));
    cyc(2);
    chk("R7 fifo holds data", hold_empty, 1'b0);
    chk("R10 fifo nonempty shift flag", shift_empty, 1'b0);
    tick_per = 1;
    cyc(300);
    rd_isr();            // R12
    cyc(100);
    trig_sel = 2'b01;
    drain();

    // R8 R11: flush by leaving FIFO mode while bytes wait, trigger 14
    scen = "fifo_flush";
    tick_per = 0; trig_sel = 2'b11;
    for (int i = 0; i < 5; i++) wr(8'hC0 + 8'(i));
    tick_per = 1; cyc(10);
    fifo_en = 1'b0; cyc(2);
    chk("R8 flushed", hold_empty, 1'b1);
    drain();

    // R8: re-enter FIFO mode, short burst, trigger 1
    scen = "fifo_reenter";
    fifo_en = 1'b1; trig_sel = 2'b00; cyc(2);
    wr(8'h81); wr(8'h42); wr(8'h24);
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule